// File: doc/BRIEF.md
# Vector Bitwise Logic and Select Unit

This block performs bitwise operations on 64- or 128-bit vectors. It covers the two-operand logic functions (AND, OR, XOR, AND with inverted second operand, OR with inverted second operand). It also has three bit-insert and bit-select operations that merge the two source operands into the previous destination value, and a lane-wise test-bits compare. There is no arithmetic. A width flag chooses between a 64-bit operation on the low half and a full 128-bit operation. A size code sets the lane width of the test compare.

Operations enter through a valid/ready stream and leave, one cycle later, through a second valid/ready stream that is held in a single output register. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the unit can accept one operation per clock as long as the consumer keeps `out_ready` high. While `out_valid` is high and `out_ready` is low, the output data is frozen and no new input is taken.

Top module: `vbl_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted operation appears on `out_data` with `out_valid` high at the next clock edge, and `out_data` and `out_valid` stay unchanged while `out_valid` is high and `out_ready` is low.
- R3: Op code 0 gives n AND m, op code 1 gives n OR m, and op code 2 gives n XOR m.
- R4: Op code 3 gives n AND NOT m, and op code 4 gives n OR NOT m.
- R5: Op code 5 (insert where true) gives d XOR ((d XOR n) AND m). Each bit takes n where m is 1 and keeps d where m is 0.
- R6: Op code 6 (insert where false) gives d XOR ((d XOR n) AND NOT m). Each bit takes n where m is 0 and keeps d where m is 1.
- R7: Op code 7 (bit select) gives m XOR ((m XOR n) AND d). Each bit takes n where d is 1 and m where d is 0.
- R8: Op code 8 (test bits) splits the vector into lanes of 8 << size bits (size 0..3 gives 8, 16, 32, 64). A lane is all ones if (n AND m) is nonzero in that lane, and all zeros otherwise.
- R9: With `in_wide` = 0 only the low 64 bits are computed, and bits 127:64 of the result are zero for every op code.
- R10: Op code 8 with size 3 and `in_wide` = 0 is reserved and gives an all-zero result.
- R11: Op codes 9 to 15 give an all-zero result.
- R12: The size code has no effect on op codes 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 4 | Operation code |
| in_wide | input | 1 | 1: 128-bit operation, 0: 64-bit operation |
| in_size | input | 2 | Lane size code for test bits |
| in_n | input | 128 | First source operand |
| in_m | input | 128 | Second source operand |
| in_d | input | 128 | Previous destination value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result vector |

## Verification
The assertions assume that the input operands are known, non-X values whenever `in_valid` is high. They also assume that the consumer's `out_ready` may change freely from cycle to cycle, while the producer holds its operation stable until it is accepted. The bench follows both rules. Its driver changes inputs only half a cycle away from the clock edge and holds each operation until `in_ready` is seen high. It toggles `out_ready` with a pseudo-random pattern, so that stalls and back-to-back transfers both occur. The stimulus covers every op code, both widths and every size code, including the reserved test-bits encoding.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  typedef enum logic [3:0] {
    OP_AND    = 4'd0,
    OP_OR     = 4'd1,
    OP_XOR    = 4'd2,
    OP_ANDN   = 4'd3,
    OP_ORN    = 4'd4,
    OP_INS_T  = 4'd5,
    OP_INS_F  = 4'd6,
    OP_BSEL   = 4'd7,
    OP_TST    = 4'd8
  } vbl_op_e;

  localparam int unsigned SIZE_CODES = 4;
endpackage

// File: rtl/vbl_logic_core.sv
module vbl_logic_core
  import vbl_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [3:0]       op,
  input  logic [VEC_W-1:0] opn,
  input  logic [VEC_W-1:0] opm,
  input  logic [VEC_W-1:0] opd,
  output logic [VEC_W-1:0] res,
  output logic             hit
);
  logic [VEC_W-1:0] base, ins, mask, merged;
  logic             is_sel;

  // Shared merge datapath for the three insert/select variants.
  always_comb begin
    base   = opd;
    ins    = opn;
    mask   = opm;
    is_sel = 1'b1;
    unique case (op)
      OP_INS_T: mask = opm;
      OP_INS_F: mask = ~opm;
      OP_BSEL: begin
        base = opm;
        mask = opd;
      end
      default: is_sel = 1'b0;
    endcase
    merged = base ^ ((base ^ ins) & mask);
  end

  always_comb begin
    hit = 1'b1;
    res = '0;
    unique case (op)
      OP_AND:  res = opn & opm;
      OP_OR:   res = opn | opm;
      OP_XOR:  res = opn ^ opm;
      OP_ANDN: res = opn & ~opm;
      OP_ORN:  res = opn | ~opm;
      OP_INS_T, OP_INS_F, OP_BSEL: res = merged;
      default: hit = 1'b0;
    endcase
  end

  // R5 R6 R7: masked-off bits keep the base, masked-on bits take the insert value
  always_comb begin
    if (is_sel) begin
      a_r7_sel_keep: assert ((merged & ~mask) == (base & ~mask));
      a_r7_sel_take: assert ((merged & mask) == (ins & mask));
    end
  end
endmodule

// File: rtl/vbl_test_lanes.sv
module vbl_test_lanes
  import vbl_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [1:0]       size,
  input  logic [VEC_W-1:0] opn,
  input  logic [VEC_W-1:0] opm,
  output logic [VEC_W-1:0] res
);
  logic [VEC_W-1:0] anded;
  logic [VEC_W-1:0] per_size [SIZE_CODES];

  assign anded = opn & opm;

  for (genvar s = 0; s < SIZE_CODES; s++) begin : g_sz
    localparam int unsigned LW = 8 << s;
    localparam int unsigned NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_ln
      assign per_size[s][l*LW +: LW] = {LW{|anded[l*LW +: LW]}};
    end
  end

  assign res = per_size[size];

  // R8: a result lane of the widest size is either all ones or all zeros
  always_comb begin
    a_r8_lane_uniform: assert (per_size[3][63:0] == '0 || per_size[3][63:0] == '1);
  end
endmodule

// File: rtl/vbl_out_stage.sv
module vbl_out_stage #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r2_fall_only_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  a_r2_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/vbl_unit.sv
module vbl_unit
  import vbl_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic             in_wide,
  input  logic [1:0]       in_size,
  input  logic [VEC_W-1:0] in_n,
  input  logic [VEC_W-1:0] in_m,
  input  logic [VEC_W-1:0] in_d,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  localparam int unsigned HALF = VEC_W / 2;

  logic [VEC_W-1:0] core_res, tst_res, raw, masked;
  logic             core_hit, reserved;

  vbl_logic_core #(.VEC_W(VEC_W)) core_i (
    .op(in_op), .opn(in_n), .opm(in_m), .opd(in_d),
    .res(core_res), .hit(core_hit)
  );

  vbl_test_lanes #(.VEC_W(VEC_W)) tst_i (
    .size(in_size), .opn(in_n), .opm(in_m), .res(tst_res)
  );

  assign reserved = (in_size == 2'd3) && !in_wide;

  always_comb begin
    raw = '0;
    if (in_op == OP_TST) raw = reserved ? '0 : tst_res;
    else if (core_hit)   raw = core_res;
  end

  assign masked = in_wide ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};

  vbl_out_stage #(.VEC_W(VEC_W)) out_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(masked),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_wide |=> out_data[VEC_W-1:HALF] == '0);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 4'd8 && in_size == 2'd3 && !in_wide
    |=> out_data == '0);

  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op > 4'd8 |=> out_data == '0);

  a_r3_and: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 4'd0 && in_wide
    |=> out_data == ($past(in_n) & $past(in_m)));

  a_r1_idle: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid);
endmodule

// File: tb/vbl_unit_tb_top.sv
module vbl_unit_tb_top;
  localparam int W = 128;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_wide = 0, out_valid, out_ready = 0;
  logic [3:0] in_op = 0;
  logic [1:0] in_size = 0;
  logic [W-1:0] in_n = 0, in_m = 0, in_d = 0, out_data;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic [15:0] lfsr = 16'hACE1;
  logic stall_seen = 0;
  logic [W-1:0] stall_data;
  logic done = 0;

  always #2 clk = ~clk;

  vbl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_size(in_size),
    .in_n(in_n), .in_m(in_m), .in_d(in_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic q,
      input logic [1:0] sz, input logic [W-1:0] n, input logic [W-1:0] m,
      input logic [W-1:0] d);
    logic [W-1:0] r;
    r = '0;
    case (op)
      4'd0: r = n & m;
      4'd1: r = n | m;
      4'd2: r = n ^ m;
      4'd3: r = n & ~m;
      4'd4: r = n | ~m;
      4'd5: for (int i = 0; i < W; i++) r[i] = m[i] ? n[i] : d[i];
      4'd6: for (int i = 0; i < W; i++) r[i] = m[i] ? d[i] : n[i];
      4'd7: for (int i = 0; i < W; i++) r[i] = d[i] ? n[i] : m[i];
      4'd8: if (!(sz == 2'd3 && !q)) begin
        int lw;
        lw = 8 << sz;
        for (int l = 0; l < W / lw; l++) begin
          logic any;
          any = 1'b0;
          for (int b = 0; b < lw; b++) any = any | (n[l*lw+b] & m[l*lw+b]);
          for (int b = 0; b < lw; b++) r[l*lw+b] = any;
        end
      end
      default: r = '0;
    endcase
    if (!q) r[W-1:W/2] = '0;
    return r;
  endfunction

  task automatic send(input logic [3:0] op, input logic q, input logic [1:0] sz,
      input logic [W-1:0] n, input logic [W-1:0] m, input logic [W-1:0] d,
      input string tag);
    in_op = op; in_wide = q; in_size = sz; in_n = n; in_m = m; in_d = d;
    in_valid = 1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back(model(op, q, sz, n, m, d));
    tag_q.push_back(tag);
    @(negedge clk); #1;
    in_valid = 0;
  endtask

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Monitor and consumer: sets out_ready for the coming edge, then compares
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = done ? 1'b1 : (lfsr[1:0] != 2'b00);
      #1;
      if (stall_seen && out_valid) begin
        checks++;
        if (out_data !== stall_data) begin
          errors++;
          $display("FAIL R2 hold: got %h exp %h", out_data, stall_data);
        end
      end
      stall_seen = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready) begin
        logic [W-1:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected output: got %h exp none", out_data);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_data !== e) begin
            errors++;
            $display("FAIL %s: got %h exp %h", t, out_data, e);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, c;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: got valid=%b ready=%b exp 0 1", out_valid, in_ready);
    end
    rst_n = 1;
    @(negedge clk); #1;

    a = 128'hF0F0_1234_5678_9ABC_FFFF_0000_AAAA_5555;
    b = 128'h0FF0_FFFF_0000_1111_F0F0_FFFF_5555_5555;
    c = 128'h00FF_00FF_FF00_FF00_1234_4321_0F0F_F0F0;
    send(4'd0, 1, 0, a, b, c, "R3 and");
    send(4'd1, 1, 0, a, b, c, "R3 or");
    send(4'd2, 1, 0, a, b, c, "R3 xor");
    send(4'd3, 1, 0, a, b, c, "R4 andnot");
    send(4'd4, 1, 0, a, b, c, "R4 ornot");
    send(4'd5, 1, 0, a, b, c, "R5 insert true");
    send(4'd6, 1, 0, a, b, c, "R6 insert false");
    send(4'd7, 1, 0, a, b, c, "R7 bit select");
    send(4'd7, 1, 0, '1, '0, {64'h0, 64'hFFFF_0000_FFFF_0000}, "R7 select pattern");
    for (int s = 0; s < 4; s++) begin
      send(4'd8, 1, s[1:0], 128'h0100_0000_0000_0000_0000_0000_0080_0001,
           128'h0100_0000_0000_0000_0000_0000_0080_0000, '0, "R8 test lanes");
    end
    send(4'd8, 0, 2'd3, '1, '1, '0, "R10 reserved");
    send(4'd8, 0, 2'd2, '1, '1, '0, "R9 test narrow");
    for (int op = 0; op < 8; op++)
      send(op[3:0], 0, 2'd1, rnd(), rnd(), rnd(), "R9 narrow upper zero");
    for (int op = 9; op < 16; op++)
      send(op[3:0], 1, 2'd0, rnd(), rnd(), rnd(), "R11 unused code");
    for (int op = 0; op < 8; op++)
      send(op[3:0], 1, 2'd3, a, b, c, "R12 size ignored");
    for (int k = 0; k < 300; k++)
      send($urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 3),
           rnd(), rnd(), rnd(), "R2 random stream");
    done = 1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule